// File: doc/BRIEF.md
# DMA Burst Transfer Splitter

This block turns one DMA transfer request, given as a start byte address and a byte count, into a series of bus burst commands. Each command carries an address and a byte length. None is longer than a programmable ceiling, and that ceiling is set in 32-bit words. The commands follow each other through memory without gaps. Only the last command may be shorter than the ceiling, and it may end part-way through a word. The block moves no data. It only produces burst addresses and lengths, and it tracks when the whole transfer is finished.

Software sets the ceiling through a 32-bit configuration word. A second 32-bit word gives a read-only status view: a busy flag and the byte length of the current transaction. Requests enter through a valid/acknowledge handshake. A zero-length request is refused on a separate error line. Burst commands leave through a valid/ready handshake. A one-cycle completion pulse follows acceptance of the final burst.

Top module: `dma_burst_splitter`

## Requirements
- R1: After reset, the configuration word reads 0x00000020 (ceiling of 8 words), the status word reads 0, `burst_valid` is 0 and `done` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[11:2]` as the word ceiling. `cfg_rdata` returns that field in bits 11:2, and every other bit reads 0.
- R3: `req_ack` is high only in a cycle where `req_valid` is high, the busy flag is low and `req_len` is nonzero. The request is taken at that clock edge. A request presented while busy is not acknowledged and does not disturb the transfer in progress.
- R4: A request with `req_len` = 0 while idle raises `req_err` in the same cycle, is not acknowledged, and starts no bursts.
- R5: Each burst length equals the smaller of the remaining byte count and the ceiling times 4 bytes. A ceiling field of 0 acts as 1 word.
- R6: The first burst starts at `req_addr`. Each later burst starts at the previous burst's address plus the previous burst's byte length. The byte lengths of all bursts add up to `req_len`.
- R7: Status bit 19 (busy) is 1 from the cycle after acceptance until the final burst is taken. Status bits 11:0 hold the byte length of the latest accepted request. Bits 18:12 and 31:20 read 0.
- R8: `done` is high for exactly one cycle, the cycle after the final burst handshake. In that cycle busy reads 0 and `burst_valid` is 0.
- R9: While `burst_valid` is high and `burst_ready` is low, `burst_valid`, `burst_addr` and `burst_len` stay unchanged into the next cycle.
- R10: The ceiling is sampled when a request is accepted. Writes to the configuration word during a transfer apply only to later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data; bits 11:2 are the word ceiling |
| cfg_rdata | output | 32 | Configuration word read-back |
| status_rdata | output | 32 | Status: bit 19 busy, bits 11:0 transaction byte length |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | ADDR_W | Transfer start byte address |
| req_len | input | LEN_W | Transfer byte count, 1 to 4095 |
| req_ack | output | 1 | Request accepted this cycle |
| req_err | output | 1 | Zero-length request refused this cycle |
| burst_valid | output | 1 | Burst command present |
| burst_ready | input | 1 | Burst command taken by the bus side |
| burst_addr | output | ADDR_W | Burst start byte address |
| burst_len | output | LEN_W | Burst length in bytes |
| done | output | 1 | One-cycle pulse after the final burst is taken |

## Verification
A wrong remaining count or a wrong sampled ceiling appears on `burst_len` at the very next burst. A wrong address register appears on `burst_addr` one handshake after the error, because each address is built from the one before it. A fault in the busy flag or in completion detection shows up in the cycle after the final handshake: either the bursts continue, or `done` is missing or appears too early. The bench sweeps lengths around every ceiling multiple, across several ceilings, with back-pressure, so each of these faults appears within a few cycles of its cause.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   // Log2 of bytes per bus word (32-bit words)
   localparam int unsigned WORD_LG      = 2;
   // Position of the busy flag in the status word
   localparam int unsigned STAT_BUSY_AT = 19;
   // Register width seen by software
   localparam int unsigned REG_W        = 32;
endpackage

// File: rtl/dbs_cfg_reg.sv
module dbs_cfg_reg
   import dbs_pkg::*;
#(
   parameter int unsigned MAXW_W   = 10,
   parameter int unsigned MAXW_LSB = 2,
   parameter int unsigned MAXW_RST = 8,
   parameter int unsigned BYTES_W  = MAXW_W + WORD_LG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   output logic [MAXW_W-1:0]  max_words
);
   localparam int unsigned MSB = MAXW_LSB + MAXW_W - 1;

   if (MSB >= REG_W) begin : g_bad_field
      $error("dbs_cfg_reg: ceiling field does not fit in register");
   end
   if (MAXW_RST >= (1 << MAXW_W)) begin : g_bad_rst
      $error("dbs_cfg_reg: reset ceiling does not fit in field");
   end

   logic [MAXW_W-1:0] field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  field_q <= MAXW_W'(MAXW_RST);
      else if (we) field_q <= wdata[MSB:MAXW_LSB];
   end

   always_comb begin
      rdata = '0;
      rdata[MSB:MAXW_LSB] = field_q;
   end

   assign max_words = field_q;

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~({REG_W{1'b0}} | ((REG_W'(1) << (MSB + 1)) - (REG_W'(1) << MAXW_LSB)))) == '0);
   p_write_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata[MSB:MAXW_LSB] == $past(wdata[MSB:MAXW_LSB]));
endmodule

// File: rtl/dbs_len_calc.sv
module dbs_len_calc
   import dbs_pkg::*;
#(
   parameter int unsigned MAXW_W      = 10,
   parameter int unsigned LEN_W       = 12,
   parameter bit          ZERO_AS_ONE = 1'b1,
   parameter int unsigned BYTES_W     = MAXW_W + WORD_LG
) (
   input  logic [MAXW_W-1:0]  max_words,
   output logic [BYTES_W-1:0] max_bytes
);
   logic [MAXW_W-1:0] words_eff;

   if (ZERO_AS_ONE) begin : g_clamp
      assign words_eff = (max_words == '0) ? MAXW_W'(1) : max_words;
   end else begin : g_raw
      assign words_eff = max_words;
   end

   assign max_bytes = {words_eff, {WORD_LG{1'b0}}};

   always_comb begin
      if (ZERO_AS_ONE) a_nonzero_r5: assert (max_bytes != '0);
   end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
   import dbs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned LEN_W   = 12,
   parameter int unsigned BYTES_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [LEN_W-1:0]   req_len,
   output logic               req_ack,
   output logic               req_err,
   input  logic [BYTES_W-1:0] max_bytes,
   output logic               burst_valid,
   input  logic               burst_ready,
   output logic [ADDR_W-1:0]  burst_addr,
   output logic [LEN_W-1:0]   burst_len,
   output logic               busy,
   output logic [LEN_W-1:0]   total_len,
   output logic               done
);
   // Common width that holds both a byte count and a ceiling
   localparam int unsigned CMP_W = (LEN_W > BYTES_W) ? LEN_W : BYTES_W;

   logic              busy_q, done_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q, total_q;
   logic [CMP_W-1:0]  ceil_q;
   logic [CMP_W-1:0]  remain_x;
   logic [LEN_W-1:0]  step;
   logic              fire, last;

   assign remain_x = CMP_W'(remain_q);
   assign step     = (remain_x < ceil_q) ? remain_q : LEN_W'(ceil_q);
   assign fire     = busy_q && burst_ready;
   assign last     = (remain_q == step);

   assign req_ack  = req_valid && !busy_q && (req_len != '0);
   assign req_err  = req_valid && !busy_q && (req_len == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         addr_q   <= '0;
         remain_q <= '0;
         total_q  <= '0;
         ceil_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (req_ack) begin
            busy_q   <= 1'b1;
            addr_q   <= req_addr;
            remain_q <= req_len;
            total_q  <= req_len;
            ceil_q   <= CMP_W'(max_bytes);
         end else if (fire) begin
            addr_q   <= addr_q + ADDR_W'(step);
            remain_q <= remain_q - step;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign burst_valid = busy_q;
   assign burst_addr  = addr_q;
   assign burst_len   = step;
   assign busy        = busy_q;
   assign total_len   = total_q;
   assign done        = done_q;

   p_no_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !req_ack && !req_err);
   p_zero_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_len == '0) |-> !req_ack);
   p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> (burst_len != '0) && (CMP_W'(burst_len) <= ceil_q)
                      && (burst_len <= remain_q));
   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last) |=> burst_addr == $past(burst_addr) + ADDR_W'($past(burst_len)));
   p_busy_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> busy && total_len == $past(req_len));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !burst_valid && !$past(done));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_valid && !burst_ready) |=> burst_valid && $stable(burst_addr)
                                        && $stable(burst_len));
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
   import dbs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LEN_W    = 12,
   parameter int unsigned MAXW_W   = 10,
   parameter int unsigned MAXW_LSB = 2,
   parameter int unsigned MAXW_RST = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic [31:0]       status_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ack,
   output logic              req_err,
   output logic              burst_valid,
   input  logic              burst_ready,
   output logic [ADDR_W-1:0] burst_addr,
   output logic [LEN_W-1:0]  burst_len,
   output logic              done
);
   localparam int unsigned BYTES_W = MAXW_W + WORD_LG;

   if (LEN_W >= STAT_BUSY_AT) begin : g_bad_len
      $error("dma_burst_splitter: length field overlaps busy flag");
   end

   logic [MAXW_W-1:0]  max_words;
   logic [BYTES_W-1:0] max_bytes;
   logic               busy;
   logic [LEN_W-1:0]   total_len;

   dbs_cfg_reg #(
      .MAXW_W(MAXW_W), .MAXW_LSB(MAXW_LSB), .MAXW_RST(MAXW_RST), .BYTES_W(BYTES_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .max_words(max_words)
   );

   dbs_len_calc #(
      .MAXW_W(MAXW_W), .LEN_W(LEN_W), .ZERO_AS_ONE(1'b1), .BYTES_W(BYTES_W)
   ) u_calc (
      .max_words(max_words), .max_bytes(max_bytes)
   );

   dbs_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES_W(BYTES_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
      .req_ack(req_ack), .req_err(req_err), .max_bytes(max_bytes),
      .burst_valid(burst_valid), .burst_ready(burst_ready),
      .burst_addr(burst_addr), .burst_len(burst_len),
      .busy(busy), .total_len(total_len), .done(done)
   );

   always_comb begin
      status_rdata = '0;
      status_rdata[LEN_W-1:0]    = total_len;
      status_rdata[STAT_BUSY_AT] = busy;
   end

   p_status_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_rdata[31:STAT_BUSY_AT+1] == '0 && status_rdata[STAT_BUSY_AT-1:LEN_W] == '0);
   p_busy_matches_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_rdata[STAT_BUSY_AT] == burst_valid);
endmodule

// File: tb/test_dma_burst_splitter.sv
module test_dma_burst_splitter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata, status_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [11:0] req_len = '0;
   logic        req_ack, req_err;
   logic        burst_valid;
   logic        burst_ready = 1'b0;
   logic [31:0] burst_addr;
   logic [11:0] burst_len;
   logic        done;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   dma_burst_splitter i_dma_burst_splitter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .status_rdata(status_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
      .req_ack(req_ack), .req_err(req_err),
      .burst_valid(burst_valid), .burst_ready(burst_ready),
      .burst_addr(burst_addr), .burst_len(burst_len), .done(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic write_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      #1 chk("R2 cfg readback", cfg_rdata, v & 32'h0000_0FFC);
   endtask

   // One transfer; ceiling words in effect at acceptance is `words`.
   task automatic run_xfer(input logic [31:0] addr, input int len, input int words,
                           input bit stall, input bit disturb, input logic [31:0] newcfg);
      int eff, rem, bl, it;
      logic [31:0] a;
      eff = ((words == 0) ? 1 : words) * 4;
      rem = len; a = addr; it = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_len = 12'(len);
      #1 chk("R3 ack when idle", {30'd0, req_err, req_ack}, 32'd1);
      while (rem > 0) begin
         @(negedge clk);
         req_valid = 1'b0; cfg_we = 1'b0;
         burst_ready = stall ? ((it % 3) != 1) : 1'b1;
         if (disturb && it == 0) begin
            cfg_we = 1'b1; cfg_wdata = newcfg;
            req_valid = 1'b1; req_addr = 32'h55; req_len = 12'd5;
         end
         #1;
         bl = (rem < eff) ? rem : eff;
         chk("R7 busy", {31'd0, status_rdata[19]}, 32'd1);
         chk("R7 length", status_rdata, 32'h0008_0000 | 32'(len));
         chk("R6 addr", burst_addr, a);
         chk("R5 len", {20'd0, burst_len}, 32'(bl));
         chk("R9 valid", {31'd0, burst_valid}, 32'd1);
         if (disturb && it == 0) chk("R3 busy no ack", {31'd0, req_ack}, 32'd0);
         if (burst_ready) begin rem -= bl; a += 32'(bl); end
         it++;
      end
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0; burst_ready = 1'b0;
      #1;
      chk("R8 done", {31'd0, done}, 32'd1);
      chk("R8 idle", {30'd0, status_rdata[19], burst_valid}, 32'd0);
      @(negedge clk);
      #1 chk("R8 single pulse", {31'd0, done}, 32'd0);
   endtask

   initial begin
      int ws[6] = '{0, 1, 2, 3, 8, 1023};
      int ls[14] = '{1, 2, 3, 4, 5, 7, 8, 12, 31, 32, 33, 100, 4092, 4095};
      #25;
      #1 chk("R1 cfg reset", cfg_rdata, 32'h0000_0020);
      chk("R1 status reset", status_rdata, 32'd0);
      chk("R1 outputs reset", {30'd0, burst_valid, done}, 32'd0);
      rst_n = 1'b1;

      run_xfer(32'h1000, 100, 8, 1'b0, 1'b0, 0);
      write_cfg(32'hFFFF_FFFF);
      write_cfg(32'h0000_0000);

      // R4 zero length
      @(negedge clk);
      req_valid = 1'b1; req_len = 12'd0;
      #1 chk("R4 err", {30'd0, req_err, req_ack}, 32'd2);
      @(negedge clk);
      req_valid = 1'b0;
      #1 chk("R4 no start", {30'd0, status_rdata[19], burst_valid}, 32'd0);

      foreach (ws[w]) begin
         write_cfg(32'(ws[w]) << 2);
         foreach (ls[l]) begin
            if (!(ws[w] <= 1 && ls[l] > 40))
               run_xfer(32'h0000_0203 + 32'(l * 64), ls[l], ws[w], (l % 2) == 1, 1'b0, 0);
         end
      end
      write_cfg(32'd1 << 2);
      run_xfer(32'hFFFF_FFF0, 4095, 1, 1'b0, 1'b0, 0);

      // R10: ceiling change mid-transfer applies only later
      write_cfg(32'd3 << 2);
      run_xfer(32'h400, 50, 3, 1'b1, 1'b1, 32'd5 << 2);
      #1 chk("R10 new cfg held", cfg_rdata, 32'd5 << 2);
      run_xfer(32'h800, 50, 5, 1'b0, 1'b0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule